// File: doc/BRIEF.md
# MMU Fault Status Generator

This block sits next to a translation lookaside structure in a small 32-bit processor and turns each lookup outcome into either a physical page address or an MMU exception. A request carries a virtual address, an access kind and the lookup result, together with the virtual and physical base addresses of the matching entry. The block first decides whether translation applies at all. This depends on the static configuration inputs and on the virtual-mode bit of the machine status register.

On a hit, or when translation is bypassed, the block answers with a physical address one cycle later. On a protection fault or a miss, it captures the complete faulting address and an exception status code, and it pulses an MMU exception request. A pending flag then stays set until the processor clears it. A second fault that arrives while that flag is set does not raise a new exception. It raises a recursive-fault error pulse instead, and the captured registers stay as they were. An illegal access kind, or a lookup result code that is not defined, raises an error pulse.

Top module: `mmu_fault_unit`

## Requirements
- R1: Translation applies only when mmu_present_i is 1, msr_vm_i is 1, and either cfg_full_i is 0 or cfg_mmu_field_i is 1. In every other case the request is treated as bypassed.
- R2: A bypassed request with a legal kind responds with rsp_hit_o=1 and rsp_bypass_o=1 (full access rights). Its rsp_paddr_o equals the virtual address with its low PAGE_BITS bits cleared.
- R3: A translated hit (result code 0) responds with rsp_hit_o=1 and rsp_bypass_o=0. Its rsp_paddr_o is phys_base + (page-aligned vaddr) - virt_base, taken modulo 2^ADDR_W. Every response output is valid in the cycle after the request, with rsp_valid_o=1.
- R4: A protection fault (result code 1) sets esr_o[4:0] to 17 for an instruction fetch (kind 2) and to 16 for a load (kind 0) or a store (kind 1).
- R5: A miss (result code 2) sets esr_o[4:0] to 19 for an instruction fetch and to 18 for a load or a store.
- R6: esr_o[10] is set to 1 when the faulting access is a store (kind 1) and to 0 otherwise. All other esr_o bits are 0.
- R7: ear_o and esr_o reset to 0. They load only when a fault is accepted, and ear_o receives the full faulting virtual address.
- R8: An accepted fault gives a one-cycle mmu_exc_o pulse in the cycle after the request and sets exc_pending_o. exc_pending_o stays 1 until a cycle with exc_clear_i=1.
- R9: A fault that arrives while exc_pending_o is 1 gives a one-cycle recursive_fault_o pulse and no mmu_exc_o. ear_o and esr_o keep their values.
- R10: Access kind 3 (any mode), or lookup result code 3 during translation, gives a one-cycle error_o pulse. Such a request gives no hit, no exception and no register update.
- R11: After reset every pulse output, rsp_paddr_o, exc_pending_o, ear_o and esr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mmu_present_i | input | 1 | Configuration: MMU built in |
| cfg_full_i | input | 1 | Configuration: full configuration set present |
| cfg_mmu_field_i | input | 1 | Configuration field reads MMU enabled |
| msr_vm_i | input | 1 | Machine status virtual-mode bit |
| req_valid_i | input | 1 | Access request strobe |
| req_vaddr_i | input | ADDR_W | Virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 fetch, 3 illegal |
| lu_result_i | input | 2 | 0 hit, 1 protection, 2 miss, 3 undefined |
| lu_pbase_i | input | ADDR_W | Matching entry physical base |
| lu_vbase_i | input | ADDR_W | Matching entry virtual base |
| exc_clear_i | input | 1 | Pending MMU exception serviced |
| rsp_valid_o | output | 1 | Response for last cycle's request |
| rsp_hit_o | output | 1 | Address produced |
| rsp_bypass_o | output | 1 | Translation bypassed, full rights |
| rsp_paddr_o | output | ADDR_W | Physical address |
| mmu_exc_o | output | 1 | MMU exception request pulse |
| exc_pending_o | output | 1 | MMU exception pending |
| recursive_fault_o | output | 1 | Fault while pending |
| error_o | output | 1 | Illegal kind or lookup code |
| ear_o | output | ADDR_W | Captured faulting address |
| esr_o | output | ESR_W | Captured status code |

## Verification
Several properties are checked on every cycle. The four outcomes (hit, exception, recursive fault, error) never occur together. An exception always leaves the pending flag set, and the flag holds until a clear. A recursive fault or any non-exception cycle leaves the captured address and status unchanged. Every exception carries a code in the range 16 to 19. A bypassed response always carries the page-aligned address of the previous request.

Some behaviour can only be shown by the bench's scenarios, which compare against a reference model. These are the exact translated address arithmetic, the code for each pairing of fault class and access kind, the store bit, the decoding of the configuration inputs, and the timing of a clear that lands in the same cycle as a fault.

// File: rtl/mmu_fault_pkg.sv
`timescale 1ns/1ps
package mmu_fault_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ILL   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    LU_HIT  = 2'd0,
    LU_PROT = 2'd1,
    LU_MISS = 2'd2,
    LU_UNDF = 2'd3
  } lu_res_e;

  localparam logic [4:0] CODE_PROT_DATA  = 5'd16;
  localparam logic [4:0] CODE_PROT_FETCH = 5'd17;
  localparam logic [4:0] CODE_MISS_DATA  = 5'd18;
  localparam logic [4:0] CODE_MISS_FETCH = 5'd19;
  localparam int unsigned STORE_BIT      = 10;
endpackage

// File: rtl/mmu_avail_dec.sv
`timescale 1ns/1ps
module mmu_avail_dec (
  input  logic present_i,
  input  logic full_i,
  input  logic field_i,
  input  logic vm_i,
  output logic xlate_o
);
  logic avail;
  // a full configuration set must also confirm the MMU
  assign avail   = present_i & (~full_i | field_i);
  assign xlate_o = avail & vm_i;
endmodule

// File: rtl/mmu_page_xlate.sv
`timescale 1ns/1ps
module mmu_page_xlate #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              xlate_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] pbase_i,
  input  logic [ADDR_W-1:0] vbase_i,
  output logic [ADDR_W-1:0] paddr_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] vpage;
  assign vpage = vaddr_i & PAGE_MASK;

  always_comb begin
    if (xlate_i) paddr_o = pbase_i + vpage - vbase_i;
    else         paddr_o = vpage;
  end
endmodule

// File: rtl/mmu_esr_gen.sv
`timescale 1ns/1ps
module mmu_esr_gen
  import mmu_fault_pkg::*;
#(
  parameter int unsigned ESR_W = 32
) (
  input  logic             xlate_i,
  input  acc_kind_e        kind_i,
  input  lu_res_e          res_i,
  output logic             fault_o,
  output logic             bad_o,
  output logic [ESR_W-1:0] code_o
);
  logic fetch;
  assign fetch = (kind_i == ACC_FETCH);

  always_comb begin
    fault_o = 1'b0;
    bad_o   = 1'b0;
    code_o  = '0;
    if (kind_i == ACC_ILL) begin
      bad_o = 1'b1;
    end else if (xlate_i) begin
      unique case (res_i)
        LU_HIT:  ;
        LU_PROT: begin
          fault_o     = 1'b1;
          code_o[4:0] = fetch ? CODE_PROT_FETCH : CODE_PROT_DATA;
        end
        LU_MISS: begin
          fault_o     = 1'b1;
          code_o[4:0] = fetch ? CODE_MISS_FETCH : CODE_MISS_DATA;
        end
        default: bad_o = 1'b1;
      endcase
      if (fault_o && kind_i == ACC_STORE) code_o[STORE_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/mmu_fault_unit.sv
`timescale 1ns/1ps
module mmu_fault_unit
  import mmu_fault_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ESR_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mmu_present_i,
  input  logic              cfg_full_i,
  input  logic              cfg_mmu_field_i,
  input  logic              msr_vm_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        lu_result_i,
  input  logic [ADDR_W-1:0] lu_pbase_i,
  input  logic [ADDR_W-1:0] lu_vbase_i,
  input  logic              exc_clear_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_bypass_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              mmu_exc_o,
  output logic              exc_pending_o,
  output logic              recursive_fault_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] ear_o,
  output logic [ESR_W-1:0]  esr_o
);
  logic              xlate;
  logic              fault, bad, accept;
  logic [ESR_W-1:0]  code;
  logic [ADDR_W-1:0] paddr;

  logic              valid_q, hit_q, bypass_q, exc_q, pend_q, rec_q, err_q;
  logic [ADDR_W-1:0] paddr_q, ear_q;
  logic [ESR_W-1:0]  esr_q;

  mmu_avail_dec u_avail (
    .present_i (mmu_present_i),
    .full_i    (cfg_full_i),
    .field_i   (cfg_mmu_field_i),
    .vm_i      (msr_vm_i),
    .xlate_o   (xlate)
  );

  mmu_page_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_xlate (
    .xlate_i (xlate),
    .vaddr_i (req_vaddr_i),
    .pbase_i (lu_pbase_i),
    .vbase_i (lu_vbase_i),
    .paddr_o (paddr)
  );

  mmu_esr_gen #(.ESR_W(ESR_W)) u_esr (
    .xlate_i (xlate),
    .kind_i  (acc_kind_e'(req_kind_i)),
    .res_i   (lu_res_e'(lu_result_i)),
    .fault_o (fault),
    .bad_o   (bad),
    .code_o  (code)
  );

  assign accept = req_valid_i & fault & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      bypass_q <= 1'b0;
      paddr_q  <= '0;
      exc_q    <= 1'b0;
      pend_q   <= 1'b0;
      rec_q    <= 1'b0;
      err_q    <= 1'b0;
      ear_q    <= '0;
      esr_q    <= '0;
    end else begin
      valid_q  <= req_valid_i;
      hit_q    <= req_valid_i & ~bad & ~fault;
      bypass_q <= req_valid_i & ~bad & ~xlate;
      if (req_valid_i) paddr_q <= paddr;
      exc_q    <= accept;
      rec_q    <= req_valid_i & fault & pend_q;
      err_q    <= req_valid_i & bad;
      pend_q   <= (pend_q & ~exc_clear_i) | accept;
      if (accept) begin
        ear_q <= req_vaddr_i;
        esr_q <= code;
      end
    end
  end

  assign rsp_valid_o       = valid_q;
  assign rsp_hit_o         = hit_q;
  assign rsp_bypass_o      = bypass_q;
  assign rsp_paddr_o       = paddr_q;
  assign mmu_exc_o         = exc_q;
  assign exc_pending_o     = pend_q;
  assign recursive_fault_o = rec_q;
  assign error_o           = err_q;
  assign ear_o             = ear_q;
  assign esr_o             = esr_q;
endmodule

// File: rtl/mmu_fault_unit_chk.sv
`timescale 1ns/1ps
module mmu_fault_unit_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ESR_W     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              exc_clear_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_bypass_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic              mmu_exc_o,
  input logic              exc_pending_o,
  input logic              recursive_fault_o,
  input logic              error_o,
  input logic [ADDR_W-1:0] ear_o,
  input logic [ESR_W-1:0]  esr_o
);
  localparam logic [ADDR_W-1:0] PMASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_hit_o, mmu_exc_o, recursive_fault_o, error_o}));

  p_exc_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_exc_o |-> exc_pending_o);

  p_pending_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(exc_pending_o) && !$past(exc_clear_i)) |-> exc_pending_o);

  p_rec_keeps_regs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recursive_fault_o |-> ($stable(ear_o) && $stable(esr_o) && !mmu_exc_o));

  p_regs_only_on_exc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mmu_exc_o |-> ($stable(ear_o) && $stable(esr_o)));

  p_code_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_exc_o |-> (esr_o[4:0] >= 5'd16 && esr_o[4:0] <= 5'd19));

  p_bypass_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_bypass_o) |-> (rsp_paddr_o == ($past(req_vaddr_i) & PMASK)));

  p_hit_needs_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o || rsp_bypass_o) |-> rsp_valid_o);
endmodule

bind mmu_fault_unit mmu_fault_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ESR_W(ESR_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_vaddr_i       (req_vaddr_i),
  .exc_clear_i       (exc_clear_i),
  .rsp_valid_o       (rsp_valid_o),
  .rsp_hit_o         (rsp_hit_o),
  .rsp_bypass_o      (rsp_bypass_o),
  .rsp_paddr_o       (rsp_paddr_o),
  .mmu_exc_o         (mmu_exc_o),
  .exc_pending_o     (exc_pending_o),
  .recursive_fault_o (recursive_fault_o),
  .error_o           (error_o),
  .ear_o             (ear_o),
  .esr_o             (esr_o)
);

// File: tb/mmu_fault_unit_tb.sv
`timescale 1ns/1ps
module mmu_fault_unit_tb;
  localparam int AW = 32;
  localparam int PB = 12;
  localparam int EW = 32;
  localparam logic [AW-1:0] PMASK = ~((AW'(1) << PB) - AW'(1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          pres = 0, full = 0, fld = 0, vm = 0, rv = 0, clr = 0;
  logic [AW-1:0] va = 0, pb = 0, vb = 0;
  logic [1:0]    kind = 0, res = 0;
  logic          o_valid, o_hit, o_byp, o_exc, o_pend, o_rec, o_err;
  logic [AW-1:0] o_pa, o_ear;
  logic [EW-1:0] o_esr;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          m_pend = 0;
  logic [AW-1:0] m_ear = 0;
  logic [EW-1:0] m_esr = 0;

  mmu_fault_unit #(.ADDR_W(AW), .PAGE_BITS(PB), .ESR_W(EW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mmu_present_i(pres), .cfg_full_i(full), .cfg_mmu_field_i(fld), .msr_vm_i(vm),
    .req_valid_i(rv), .req_vaddr_i(va), .req_kind_i(kind), .lu_result_i(res),
    .lu_pbase_i(pb), .lu_vbase_i(vb), .exc_clear_i(clr),
    .rsp_valid_o(o_valid), .rsp_hit_o(o_hit), .rsp_bypass_o(o_byp), .rsp_paddr_o(o_pa),
    .mmu_exc_o(o_exc), .exc_pending_o(o_pend), .recursive_fault_o(o_rec),
    .error_o(o_err), .ear_o(o_ear), .esr_o(o_esr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic f_xlate(logic p, logic f, logic d, logic v);
    return p && v && (!f || d);
  endfunction

  function automatic logic [EW-1:0] f_code(logic [1:0] k, logic [1:0] r);
    logic [EW-1:0] c = '0;
    if (r == 2'd1) c[4:0] = (k == 2'd2) ? 5'd17 : 5'd16;
    else           c[4:0] = (k == 2'd2) ? 5'd19 : 5'd18;
    if (k == 2'd1) c[10] = 1'b1;
    return c;
  endfunction

  task automatic do_req(logic p, logic f, logic d, logic v, logic [AW-1:0] a,
                        logic [1:0] k, logic [1:0] r, logic [AW-1:0] pbase,
                        logic [AW-1:0] vbase, logic c);
    logic x, bad, flt, acc, hit;
    logic [AW-1:0] epa;
    @(negedge clk);
    pres = p; full = f; fld = d; vm = v; va = a; kind = k; res = r;
    pb = pbase; vb = vbase; clr = c; rv = 1'b1;
    x   = f_xlate(p, f, d, v);
    bad = (k == 2'd3) || (x && r == 2'd3);
    flt = !bad && x && (r == 2'd1 || r == 2'd2);
    hit = !bad && !flt;
    acc = flt && !m_pend;
    epa = x ? (pbase + (a & PMASK) - vbase) : (a & PMASK);
    if (acc) begin m_ear = a; m_esr = f_code(k, r); end
    m_pend = (m_pend && !c) || acc;
    @(negedge clk);
    rv = 1'b0; clr = 1'b0;
    chk("R3 rsp_valid", o_valid, 1);
    chk("R1 hit", o_hit, hit);
    chk("R1 bypass", o_byp, !bad && !x);
    if (hit) chk(x ? "R3 paddr" : "R2 paddr", o_pa, epa);
    chk("R8 exc", o_exc, acc);
    chk("R9 recursive", o_rec, flt && !acc);
    chk("R10 error", o_err, bad);
    chk("R8 pending", o_pend, m_pend);
    chk("R7 ear", o_ear, m_ear);
    chk("R4 R5 R6 esr", o_esr, m_esr);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    m_pend = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk("R8 cleared", o_pend, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R11 ear", o_ear, 0);
    chk("R11 esr", o_esr, 0);
    chk("R11 pending", o_pend, 0);
    chk("R11 pulses", {o_valid, o_hit, o_exc, o_rec, o_err}, 0);
    rst_n = 1'b1;

    // R2 bypass under each disabling condition
    do_req(0, 0, 0, 1, 32'hDEAD_BEEF, 0, 2, 32'h1000, 0, 0);
    do_req(1, 0, 0, 0, 32'h1234_5678, 1, 1, 32'h1000, 0, 0);
    do_req(1, 1, 0, 1, 32'hCAFE_0FFF, 2, 2, 0, 0, 0);
    // R3 translated hit
    do_req(1, 1, 1, 1, 32'h0040_2ABC, 0, 0, 32'h8000_0000, 32'h0040_0000, 0);
    // R4 protection fetch: 17, then recursive R9
    do_req(1, 0, 0, 1, 32'h0000_1F04, 2, 1, 0, 0, 0);
    do_req(1, 0, 0, 1, 32'h0000_2000, 0, 2, 0, 0, 0);
    do_clear();
    // R6 store miss: 18 | bit10
    do_req(1, 0, 0, 1, 32'hFFFF_FFFF, 1, 2, 0, 0, 0);
    // fault with same-cycle clear: recursive, pending drops
    do_req(1, 0, 0, 1, 32'h0000_3000, 0, 1, 0, 0, 1);
    // R5 fetch miss: 19
    do_req(1, 0, 0, 1, 32'h0000_4444, 2, 2, 0, 0, 0);
    do_clear();
    // R10 illegal kind and undefined result
    do_req(1, 0, 0, 1, 32'h5555_0000, 3, 0, 0, 0, 0);
    do_req(1, 0, 0, 1, 32'h6666_0000, 0, 3, 0, 0, 0);
    do_req(0, 0, 0, 0, 32'h7777_0000, 0, 3, 0, 0, 0);
    // R4 protection load: 16
    do_req(1, 0, 0, 1, 32'h0000_8008, 0, 1, 0, 0, 0);
    do_clear();

    for (int i = 0; i < 400; i++) begin
      logic on;
      logic [1:0] k, r;
      on = ($urandom_range(9) < 7);
      k  = ($urandom_range(15) == 0) ? 2'd3 : 2'($urandom_range(2));
      r  = ($urandom_range(15) == 0) ? 2'd3 : 2'($urandom_range(2));
      do_req(on ? 1'b1 : 1'($urandom_range(1)), 1'($urandom_range(1)),
             on ? 1'b1 : 1'($urandom_range(1)), on ? 1'b1 : 1'($urandom_range(1)),
             $urandom(), k, r, $urandom() & PMASK, $urandom() & PMASK,
             ($urandom_range(3) == 0));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule